// File: doc/BRIEF.md
# Receive Byte Queue with Level and Idle Interrupts

This block buffers bytes arriving from a serial receiver until the host collects them. A deserializer pulses a write strobe with each received byte. The host pulls bytes out with a read strobe and sees the oldest byte on the read-data output. Two interrupt lines tell the host when to service the queue:

- A level interrupt fires when the stored count reaches a selectable trigger level.
- An idle interrupt fires when bytes have waited with no traffic for a programmed number of bit-time ticks. This drains short bursts that never reach the trigger level.

Out of reset the block runs in a compatibility mode with a single holding slot. In that mode every received byte raises the level interrupt. Setting the queue-enable input switches it to the full depth. A byte that arrives with no free slot is discarded and latches an overrun flag, which the host clears by reading status. A flush input empties the queue at once.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset, count is 0, rd_data is 0, and overrun, irq_data and irq_timeout are all low. The block is in single-slot mode.
- R2: With fifo_en high, up to DEPTH (16) bytes are stored and returned in arrival order. rd_data shows the oldest byte, or 0 when empty, and count follows accepted writes and reads one cycle after the strobe.
- R3: With fifo_en high, irq_data is high exactly while count is at least the trigger level given by trig_sel: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14. It drops as soon as count falls below that level.
- R4: With fifo_en low, the block holds at most one byte, and irq_data is high whenever that byte is present.
- R5: A write with no free slot, and no read in the same cycle, is dropped and sets overrun. overrun stays high until a cycle with status_rd high and no new drop; a drop in the same cycle as status_rd leaves it set.
- R6: A write and a read in the same cycle on a full queue are both taken, and count stays the same. On an empty queue the read is ignored and the byte is stored.
- R7: With fifo_en high and count above 0, irq_timeout rises after TIMEOUT_TICKS bit_tick pulses with no accepted write or read. Every accepted write or read restarts this count.
- R8: An accepted read clears irq_timeout on the next cycle.
- R9: flush empties the queue and clears the idle timer and irq_timeout in one cycle. Any write or read in that cycle is ignored.
- R10: A change of fifo_en empties the queue and clears the idle state in the cycle it is seen. Writes and reads in that cycle are ignored.
- R11: A read on an empty queue has no effect on count, rd_data or the interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte-received strobe from the deserializer |
| wr_data | input | DATA_W | Received byte |
| rd_en | input | 1 | Host read strobe (pops the oldest byte) |
| rd_data | output | DATA_W | Oldest stored byte, 0 when empty |
| status_rd | input | 1 | Host status read; clears overrun |
| flush | input | 1 | Empty the queue and the idle timer |
| fifo_en | input | 1 | 1 selects full depth, 0 selects the single slot |
| trig_sel | input | 2 | Trigger level select |
| bit_tick | input | 1 | One pulse per serial bit time |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |
| overrun | output | 1 | Sticky dropped-byte flag |
| irq_data | output | 1 | Level interrupt |
| irq_timeout | output | 1 | Idle interrupt |

## Verification
The bench builds the block with DEPTH at 16 and DATA_W at 8, and sets TIMEOUT_TICKS to 6 instead of its default of 40. The short idle window lets directed and random traffic reach the timeout many times within a short run. The full depth keeps the highest trigger level of 14 and the drop of a byte on a full queue reachable. These settings also reach a write and a read together at both the empty and the full boundary. A behavioural queue model is compared with every output on every clock. It covers mode switches, flushes and random mixes of strobes and ticks across all four trigger levels.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

    // Trigger level for the level interrupt, by select code.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   trig_level = 5'd1;
            2'b01:   trig_level = 5'd4;
            2'b10:   trig_level = 5'd8;
            default: trig_level = 5'd14;
        endcase
    endfunction

    typedef struct packed {
        logic mode;
        logic ovr;
    } ctl_state_t;

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        wrap_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (push) st_d.wr = wrap_inc(st_q.wr);
            if (pop)  st_d.rd = wrap_inc(st_q.rd);
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[st_q.wr] <= push_data;
    end

    assign head_data = (st_q.cnt != '0) ? mem[st_q.rd] : '0;
    assign count     = st_q.cnt;

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout #(
    parameter int TIMEOUT_TICKS = 40,
    localparam int TCW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic restart,
    input  logic ack,
    input  logic armed,
    input  logic tick,
    output logic expired
);

    typedef struct packed {
        logic [TCW-1:0] cnt;
        logic           flag;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (ack) st_d.flag = 1'b0;
            if (restart) begin
                st_d.cnt = '0;
            end else if (armed && !st_q.flag && tick) begin
                if (st_q.cnt == TCW'(TIMEOUT_TICKS - 1)) begin
                    st_d.flag = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.flag;

endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 16,
    parameter int TIMEOUT_TICKS = 40,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              status_rd,
    input  logic              flush,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              bit_tick,
    output logic [CNT_W-1:0]  count,
    output logic              overrun,
    output logic              irq_data,
    output logic              irq_timeout
);

    ctl_state_t st_d, st_q;

    logic             clr;
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] cnt_w;
    logic             mode_r;

    always_comb begin
        st_d  = st_q;
        clr   = flush || (fifo_en != st_q.mode);
        cap   = st_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
        pop   = !clr && rd_en && (cnt_w != '0);
        push  = !clr && wr_en && ((cnt_w < cap) || pop);
        level = st_q.mode ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);

        st_d.mode = fifo_en;
        if (wr_en && !clr && !push) st_d.ovr = 1'b1;
        else if (status_rd)         st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rx_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr),
        .push      (push),
        .pop       (pop),
        .push_data (wr_data),
        .head_data (rd_data),
        .count     (cnt_w)
    );

    rx_fifo_timeout #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) tmo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .restart (push || pop),
        .ack     (pop),
        .armed   (st_q.mode && (cnt_w != '0)),
        .tick    (bit_tick),
        .expired (irq_timeout)
    );

    assign count    = cnt_w;
    assign overrun  = st_q.ovr;
    assign irq_data = (cnt_w >= level);
    assign mode_r   = st_q.mode;

endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             flush,
    input logic             fifo_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] count,
    input logic             overrun,
    input logic             irq_data,
    input logic             irq_timeout,
    input logic             mode_r
);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R4
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_r |-> count <= CNT_W'(1));

    // R3
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r && trig_sel == 2'b11 && count < CNT_W'(14)) |-> !irq_data);

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r && fifo_en && !flush && wr_en && !rd_en && count == CNT_W'(DEPTH)) |=> overrun);

    // R6
    full_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r && fifo_en && !flush && wr_en && rd_en && count == CNT_W'(DEPTH))
        |=> count == CNT_W'(DEPTH));

    // R8
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == fifo_en && !flush && rd_en && count != '0) |=> !irq_timeout);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !irq_timeout));

endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .flush       (flush),
    .fifo_en     (fifo_en),
    .trig_sel    (trig_sel),
    .count       (count),
    .overrun     (overrun),
    .irq_data    (irq_data),
    .irq_timeout (irq_timeout),
    .mode_r      (mode_r)
);

// File: tb/rx_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_irq_tb_top;

    localparam int DW = 8;
    localparam int DP = 16;
    localparam int TT = 6;
    localparam int CW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          status_rd = 1'b0;
    logic          flush = 1'b0;
    logic          fifo_en = 1'b0;
    logic [1:0]    trig_sel = 2'b00;
    logic          bit_tick = 1'b0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] count;
    logic          overrun, irq_data, irq_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    rx_fifo_irq #(.DATA_W(DW), .DEPTH(DP), .TIMEOUT_TICKS(TT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .status_rd(status_rd), .flush(flush), .fifo_en(fifo_en),
        .trig_sel(trig_sel), .bit_tick(bit_tick), .count(count), .overrun(overrun),
        .irq_data(irq_data), .irq_timeout(irq_timeout)
    );

    // behavioural reference
    logic [DW-1:0] mq[$];
    bit m_mode, m_ovr, m_flag;
    int m_tmr;

    function automatic int lvl(input bit mode, input logic [1:0] s);
        if (!mode) return 1;
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_mode = 0; m_ovr = 0; m_flag = 0; m_tmr = 0;
        end else begin
            bit clr, dpop, dpush, armed;
            int n;
            n     = mq.size();
            clr   = flush || (fifo_en != m_mode);
            dpop  = !clr && rd_en && n > 0;
            dpush = !clr && wr_en && (n < (m_mode ? DP : 1) || dpop);
            armed = m_mode && n > 0;
            if (wr_en && !clr && !dpush) m_ovr = 1;
            else if (status_rd) m_ovr = 0;
            if (clr) begin
                mq.delete(); m_flag = 0; m_tmr = 0;
            end else begin
                if (dpop) begin void'(mq.pop_front()); m_flag = 0; end
                if (dpush) mq.push_back(wr_data);
                if (dpush || dpop) m_tmr = 0;
                else if (armed && !m_flag && bit_tick) begin
                    if (m_tmr == TT - 1) begin m_flag = 1; m_tmr = 0; end
                    else m_tmr++;
                end
            end
            m_mode = fifo_en;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            int n;
            n = mq.size();
            chk(count == CW'(n), "R2 count", count, n);
            chk(rd_data == (n > 0 ? mq[0] : 8'd0), "R2 rd_data", rd_data, n > 0 ? mq[0] : 0);
            chk(overrun == m_ovr, "R5 overrun", overrun, m_ovr);
            chk(irq_data == (n >= lvl(m_mode, trig_sel)), "R3 irq_data", irq_data,
                n >= lvl(m_mode, trig_sel));
            chk(irq_timeout == m_flag, "R7 irq_timeout", irq_timeout, m_flag);
        end
    end

    task automatic step(input bit w, input logic [DW-1:0] d, input bit r,
                        input bit st = 0, input bit fl = 0, input bit tk = 0);
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; status_rd = st; flush = fl; bit_tick = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, tk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(count == 0 && !irq_data && !irq_timeout && !overrun && rd_data == 0, "R1 reset",
            {count, irq_data, irq_timeout, overrun}, 0);

        // R4 single-slot mode
        step(1, 8'hA5, 0);
        chk(count == 1 && irq_data, "R4 slot filled", {count, irq_data}, {5'd1, 1'b1});
        step(1, 8'h3C, 0);
        chk(count == 1 && rd_data == 8'hA5 && overrun, "R4 second byte dropped", rd_data, 8'hA5);
        step(0, 0, 0, 1);
        chk(!overrun, "R5 status read clears", overrun, 0);
        step(0, 0, 1);
        chk(count == 0 && !irq_data, "R4 slot read", count, 0);
        step(0, 0, 1);
        chk(count == 0 && rd_data == 0 && !irq_data, "R11 empty read", count, 0);

        // switch to full depth
        fifo_en = 1'b1; trig_sel = 2'b10;
        idle(1, 0);
        for (int i = 0; i < DP; i++) begin
            step(1, DW'(8'h10 + i), 0);
            if (i == 6) chk(!irq_data, "R3 seven below level 8", irq_data, 0);
            if (i == 7) chk(irq_data, "R3 eight at level 8", irq_data, 1);
        end
        chk(count == DP, "R2 full", count, DP);
        step(1, 8'hEE, 0, 1);
        chk(overrun && count == DP, "R5 drop with status read same cycle", overrun, 1);
        step(1, 8'h77, 1);
        chk(count == DP && rd_data == 8'h11, "R6 full write+read", rd_data, 8'h11);
        for (int i = 0; i < 9; i++) step(0, 0, 1);
        chk(!irq_data && count == 7, "R3 falls below level", count, 7);
        for (int i = 0; i < 7; i++) step(0, 0, 1);
        chk(count == 0, "R2 drained", count, 0);

        // other trigger levels
        trig_sel = 2'b01;
        for (int i = 0; i < 4; i++) step(1, DW'(i), 0);
        chk(irq_data, "R3 level 4", irq_data, 1);
        trig_sel = 2'b11;
        #1 chk(!irq_data, "R3 level 14 not reached", irq_data, 0);
        trig_sel = 2'b00;
        #1 chk(irq_data, "R3 level 1", irq_data, 1);

        // R9 flush
        step(1, 8'h55, 0, 0, 1);
        chk(count == 0, "R9 flush empties", count, 0);

        // R7 timeout, R8 read clears
        step(1, 8'h61, 0);
        step(1, 8'h62, 0);
        idle(TT - 1, 1);
        chk(!irq_timeout, "R7 one tick short", irq_timeout, 0);
        idle(1, 1);
        chk(irq_timeout, "R7 idle interrupt", irq_timeout, 1);
        step(0, 0, 1, 0, 0, 1);
        chk(!irq_timeout && count == 1, "R8 read clears", irq_timeout, 0);
        idle(TT, 1);
        chk(irq_timeout, "R7 rearmed", irq_timeout, 1);
        step(0, 0, 0, 0, 1, 1);
        chk(!irq_timeout && count == 0, "R9 flush clears timeout", irq_timeout, 0);

        // R6 empty read+write
        step(1, 8'h9A, 1);
        chk(count == 1 && rd_data == 8'h9A, "R6 empty write+read", rd_data, 8'h9A);

        // R10 mode change empties
        fifo_en = 1'b0;
        idle(1, 0);
        chk(count == 0, "R10 mode change empties", count, 0);
        fifo_en = 1'b1;
        idle(1, 0);

        // random traffic, checked each cycle by the model
        for (int i = 0; i < 1500; i++) begin
            if (i % 300 == 0) trig_sel = 2'(i / 300);
            if (i == 900) fifo_en = 1'b0;
            if (i == 1000) fifo_en = 1'b1;
            step(($urandom % 3) == 0, DW'($urandom), ($urandom % 4) == 0,
                 ($urandom % 16) == 0, ($urandom % 97) == 0, ($urandom % 2) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule